// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

The block holds two timer/counter channels. Each channel is a 16-bit count held as a low byte and a high byte. A shared mode byte configures both channels, and a control byte carries two run bits and two overflow flags. A free-running prescaler divides the input clock by twelve to form a machine-cycle strobe. On each strobe a running channel advances by one, or in counter mode it advances on a falling edge of its count pin. The count pin is sampled once per machine cycle.

Four count layouts are selectable per channel:

- **Layout 0:** a 13-bit count, with five prescale bits under the high byte.
- **Layout 1:** a plain 16-bit count.
- **Layout 2:** an 8-bit count in the low byte that reloads from the high byte.
- **Layout 3:** splits channel 0 into two independent 8-bit counters.

In layout 3, channel 0's high byte borrows channel 1's run bit and overflow flag, and channel 1 freezes if it is placed in layout 3 itself. A gate bit per channel makes counting also depend on an external level input.

Software reaches every register through a single-cycle write port and a combinational read port. The counts and flags are also brought out directly.

Top module: `dual_tmr`

## Requirements
- R1: The prescaler runs from reset release. A running timer-mode channel advances by one on the 12th rising clock edge after reset release and on every 12th edge after that. At no other edge does a count change unless it is written.
- R2: With the counter-select bit set (mode bit 2 for channel 0, bit 6 for channel 1), the count pin is sampled on each machine-cycle edge. The count advances on that edge only when the previous sample was 1 and the current one is 0. The stored sample is 0 after reset.
- R3: With the gate bit set (mode bit 3 for channel 0, bit 7 for channel 1), a channel counts only while its gate input is high.
- R4: Layout 0 (mode field value 0; channel 0 uses mode bits 1:0 and channel 1 uses bits 5:4) counts {high byte, low[4:0]} as a 13-bit value. Low bits 7:5 are kept unchanged. The flag is set on the wrap from 1FFFh to 0.
- R5: In layout 1, the count is {high, low}. It wraps from FFFFh to 0000h and sets the channel flag.
- R6: In layout 2, when the low byte passes FFh it is loaded from the high byte and the flag is set. The high byte never changes except by a write.
- R7: In layout 3 on channel 0, the low byte counts under channel 0's run, gate and select bits and sets flag 0 when it passes FFh. The high byte counts machine cycles whenever run bit 1 is set, and sets flag 1 when it passes FFh. Channel 1 wraps then no longer set flag 1.
- R8: A channel 1 placed in layout 3 holds its count.
- R9: The control byte has run 0 in bit 0, run 1 in bit 1, flag 0 in bit 2 and flag 1 in bit 3. A write sets all four bits. A one-cycle pulse on ack[i] clears flag i. An overflow in the same cycle as a clear wins.
- R10: The register addresses are: mode 0, control 1, channel 0 low 2, channel 0 high 3, channel 1 low 4, channel 1 high 5. A write lands on the next edge, and it overrides an increment on that same edge. The read data shows the addressed register in the same cycle.
- R11: A channel whose run bit is 0 holds its count.
- R12: After reset, all counts, the mode byte, the run bits and the flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register |
| cnt_pin | input | 2 | External count pins, one per channel |
| gate_pin | input | 2 | Gate level inputs, one per channel |
| ack | input | 2 | Flag clear pulses, one per channel |
| ovf | output | 2 | Overflow flags |
| cnt0 | output | 16 | Channel 0 count {high, low} |
| cnt1 | output | 16 | Channel 1 count {high, low} |

## Verification
Counts and flags move only on the machine-cycle edge, which is the rising edge on which the prescaler is at its last state. A result from a pin level or gate level set before that edge is visible just after it. Register writes land one edge after the strobe, and read data follows the address combinationally.

The bench keeps its own count of edges since reset release to find each machine-cycle edge. It drives inputs and samples outputs only at falling clock edges, so every check sits a known whole number of machine cycles after its stimulus. One check places a write exactly on a machine-cycle edge to confirm that the write takes precedence.

// File: rtl/dual_tmr.sv
module dual_tmr #(
  parameter int DIV = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic [1:0]  cnt_pin,
  input  logic [1:0]  gate_pin,
  input  logic [1:0]  ack,
  output logic [1:0]  ovf,
  output logic [15:0] cnt0,
  output logic [15:0] cnt1
);
  localparam int PW = $clog2(DIV);

  logic [PW-1:0] pre;
  logic [7:0] mode_q, t0l, t0h, t1l, t1h;
  logic [1:0] run_q, ovf_q, pin_prev, fall, ev, ov_evt;
  logic [16:0] s0, s1;
  logic tick, split, hi_inc, inc1;

  function automatic logic [16:0] step(input logic [1:0] m, input logic [7:0] lo,
                                       input logic [7:0] hi, input logic inc);
    logic [12:0] v13;
    logic [16:0] r;
    r   = {1'b0, hi, lo};
    v13 = {hi, lo[4:0]} + 13'd1;
    if (inc) begin
      case (m)
        2'd0:    r = {&{hi, lo[4:0]}, v13[12:5], lo[7:5], v13[4:0]};
        2'd1:    r = {&{hi, lo}, {hi, lo} + 16'd1};
        2'd2:    r = (lo == 8'hFF) ? {1'b1, hi, hi} : {1'b0, hi, lo + 8'd1};
        default: r = {&lo, hi, lo + 8'd1};
      endcase
    end
    return r;
  endfunction

  assign tick  = (pre == PW'(DIV - 1));
  assign fall  = pin_prev & ~cnt_pin;
  assign split = (mode_q[1:0] == 2'd3);

  for (genvar i = 0; i < 2; i++) begin : g_ev
    assign ev[i] = tick & run_q[i] & (~mode_q[4*i+3] | gate_pin[i]) &
                   (mode_q[4*i+2] ? fall[i] : 1'b1);
  end

  assign inc1   = ev[1] & (mode_q[5:4] != 2'd3);
  assign hi_inc = split & tick & run_q[1];
  assign s0     = step(mode_q[1:0], t0l, t0h, ev[0]);
  assign s1     = step(mode_q[5:4], t1l, t1h, inc1);
  assign ov_evt = {split ? (hi_inc & (t0h == 8'hFF)) : s1[16], s0[16]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre      <= '0;
      pin_prev <= '0;
      mode_q   <= '0;
      run_q    <= '0;
      ovf_q    <= '0;
      t0l <= '0; t0h <= '0; t1l <= '0; t1h <= '0;
    end else begin
      pre <= tick ? '0 : pre + PW'(1);
      if (tick) pin_prev <= cnt_pin;
      if (wr_en && addr == 3'd0) mode_q <= wdata;
      if (wr_en && addr == 3'd1) run_q <= wdata[1:0];
      for (int i = 0; i < 2; i++)
        ovf_q[i] <= ov_evt[i] | ((wr_en && addr == 3'd1) ? wdata[2+i] : (ovf_q[i] & ~ack[i]));
      t0l <= (wr_en && addr == 3'd2) ? wdata : s0[7:0];
      t0h <= (wr_en && addr == 3'd3) ? wdata : (split ? t0h + {7'd0, hi_inc} : s0[15:8]);
      t1l <= (wr_en && addr == 3'd4) ? wdata : s1[7:0];
      t1h <= (wr_en && addr == 3'd5) ? wdata : s1[15:8];
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rdata = mode_q;
      3'd1:    rdata = {4'd0, ovf_q, run_q};
      3'd2:    rdata = t0l;
      3'd3:    rdata = t0h;
      3'd4:    rdata = t1l;
      3'd5:    rdata = t1h;
      default: rdata = 8'd0;
    endcase
  end

  assign ovf  = ovf_q;
  assign cnt0 = {t0h, t0l};
  assign cnt1 = {t1h, t1l};
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        tick,
  input logic [1:0]  ack,
  input logic [1:0]  ov_evt,
  input logic [7:0]  mode,
  input logic [1:0]  run,
  input logic [15:0] cnt0,
  input logic [15:0] cnt1,
  input logic [1:0]  ovf
);
  p_tick_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> ($stable(cnt0) && $stable(cnt1)));

  p_ack_clr0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack[0] && !ov_evt[0] && !wr_en) |=> !ovf[0]);

  p_ack_clr1_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack[1] && !ov_evt[1] && !wr_en) |=> !ovf[1]);

  p_run_hold0_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run[0] && mode[1:0] != 2'd3 && !wr_en) |=> $stable(cnt0));

  p_run_hold1_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run[1] && !wr_en) |=> $stable(cnt1));

  p_reload_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[5:4] == 2'd2 && !wr_en) |=> $stable(cnt1[15:8]));

  p_t1_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[5:4] == 2'd3 && !wr_en) |=> $stable(cnt1));
endmodule

bind dual_tmr tmr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tick(tick), .ack(ack),
  .ov_evt(ov_evt), .mode(mode_q), .run(run_q), .cnt0(cnt0), .cnt1(cnt1), .ovf(ovf)
);

// File: tb/sim_dual_tmr.sv
module sim_dual_tmr;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [1:0] cnt_pin = 0, gate_pin = 0, ack = 0;
  wire  [7:0] rdata;
  wire  [1:0] ovf;
  wire  [15:0] cnt0, cnt1;
  int tests = 0, fails = 0;
  int unsigned ecount;

  always #10 clk = ~clk;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) ecount <= 0; else ecount <= ecount + 1;

  dual_tmr u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cnt_pin(cnt_pin), .gate_pin(gate_pin), .ack(ack), .ovf(ovf),
    .cnt0(cnt0), .cnt1(cnt1));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic tick1();
    while (ecount % 12 != 11) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick1();
  endtask

  task automatic load0(logic [15:0] v); wr(2, v[7:0]); wr(3, v[15:8]); endtask
  task automatic load1(logic [15:0] v); wr(4, v[7:0]); wr(5, v[15:8]); endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [16:0] e;
    int unsigned cnt;
    logic prevb;
    logic [15:0] pat;
    logic [15:0] starts [5];
    starts = '{16'h00FF, 16'h0FFE, 16'hFFFD, 16'h7FFF, 16'hFFFF};
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 reset state
    check("R12 cnt0", cnt0, 0);
    check("R12 cnt1", cnt1, 0);
    check("R12 ovf", ovf, 0);
    rd(0, v); check("R12 mode", v, 0);
    rd(1, v); check("R12 ctrl", v, 0);

    // R1 machine-cycle timing, R11 channel 1 stopped
    wr(0, 8'h11); wr(1, 8'h01);
    tick1(); check("R1 first tick", cnt0, 1);
    repeat (11) @(negedge clk);
    check("R1 no change before 12th edge", cnt0, 1);
    @(negedge clk); check("R1 12th edge", cnt0, 2);
    check("R11 stopped channel holds", cnt1, 0);

    // R5 16-bit sweep
    foreach (starts[k]) begin
      wr(1, 0); load0(starts[k]); wr(1, 8'h01);
      ticks(3);
      e = {1'b0, starts[k]} + 17'd3;
      check("R5 count", cnt0, e[15:0]);
      check("R5 flag", ovf[0], e[16]);
    end

    // R4 13-bit layout
    wr(1, 0); wr(0, 8'h10); load0(16'hFFFE); wr(1, 8'h01);
    tick1(); check("R4 count", cnt0, 16'hFFFF); check("R4 no flag", ovf[0], 0);
    tick1(); check("R4 wrap keeps low[7:5]", cnt0, 16'h00E0); check("R4 flag", ovf[0], 1);
    wr(1, 0); load0(16'h051F); wr(1, 8'h01);
    tick1(); check("R4 carry into high", cnt0, 16'h0600);

    // R6 reload sweep on channel 1
    wr(1, 0); wr(0, 8'h21);
    for (int r = 0; r < 256; r += 17) begin
      wr(1, 0); wr(4, 8'hFE); wr(5, r[7:0]); wr(1, 8'h02);
      tick1(); check("R6 pre", cnt1, {r[7:0], 8'hFF});
      tick1(); check("R6 reload", cnt1, {r[7:0], r[7:0]}); check("R6 flag", ovf[1], 1);
      tick1(); check("R6 after", cnt1, {r[7:0], (r == 255) ? 8'hFF : r[7:0] + 8'd1});
    end

    // R7 split layout
    wr(1, 0); wr(0, 8'h13); load0(16'hFEFE); load1(16'h0000); wr(1, 8'h03);
    tick1(); check("R7 t0", cnt0, 16'hFFFF); check("R7 t1", cnt1, 1);
    tick1(); check("R7 both wrap", cnt0, 16'h0000); check("R7 flags", ovf, 2'b11); check("R7 t1 b", cnt1, 2);
    wr(1, 8'h01);
    tick1(); check("R7 low only", cnt0, 16'h0001); check("R7 t1 stopped", cnt1, 2);
    wr(1, 8'h02);
    tick1(); check("R7 high only", cnt0, 16'h0101); check("R7 t1 runs", cnt1, 3);
    wr(1, 8'h00); load0(16'h0000); load1(16'hFFFF); wr(1, 8'h02);
    tick1(); check("R7 t1 wraps", cnt1, 0); check("R7 t1 wrap no flag", ovf[1], 0);

    // R8 channel 1 in layout 3
    wr(1, 0); wr(0, 8'h31); load1(16'h1234); wr(1, 8'h03);
    ticks(3); check("R8 hold", cnt1, 16'h1234);

    // R2 counter mode
    wr(1, 0); wr(0, 8'h15); load0(0); cnt_pin[0] = 0; tick1(); wr(1, 8'h01);
    pat = 16'b1011_0010_1110_0100; cnt = 0; prevb = 0;
    for (int i = 0; i < 16; i++) begin
      cnt_pin[0] = pat[i];
      tick1();
      if (prevb && !pat[i]) cnt++;
      prevb = pat[i];
      check("R2 edge count", cnt0, cnt);
    end

    // R3 gate
    wr(1, 0); wr(0, 8'h91); load1(0); gate_pin[1] = 0; wr(1, 8'h02);
    ticks(3); check("R3 gate low", cnt1, 0);
    gate_pin[1] = 1;
    ticks(3); check("R3 gate high", cnt1, 3);

    // R9 flags
    wr(1, 0); wr(1, 8'h0C); rd(1, v); check("R9 write sets", v, 8'h0C);
    ack = 2'b01; @(negedge clk); ack = 0;
    check("R9 ack clears", ovf, 2'b10);
    wr(1, 8'h00); check("R9 write clears", ovf, 2'b00);

    // R10 register map and write precedence
    wr(0, 8'h11); wr(2, 8'hA1); wr(3, 8'hB2); wr(4, 8'hC3); wr(5, 8'hD4);
    rd(0, v); check("R10 mode", v, 8'h11);
    rd(2, v); check("R10 t0l", v, 8'hA1);
    rd(3, v); check("R10 t0h", v, 8'hB2);
    rd(4, v); check("R10 t1l", v, 8'hC3);
    rd(5, v); check("R10 t1h", v, 8'hD4);
    load0(16'h0010); wr(1, 8'h01);
    while (ecount % 12 != 11) @(negedge clk);
    wr(2, 8'h55); check("R10 write wins", cnt0, 16'h0055);
    tick1(); check("R10 after write", cnt0, 16'h0056);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule